// File: doc/BRIEF.md
# Multi-Phase Pulse Clock Generator

The block divides an incoming clock into two slower clocks and a set of phase pulses that share out a two-cycle frame. `clk2` runs at half the input rate and `clk4` at a quarter of it. The two-cycle frame of `clk2` is cut into four half-cycle slots. Each of the pulses `p1` to `p4` owns exactly one slot. `p23` covers the middle two slots without a break. Downstream logic can use these strobes to sequence multi-step operations without any counters of its own.

The two divided clocks are registers on the rising edge of the input clock. The pulses are decoded combinationally from the current level of the input clock and the level of `clk2`, which gives them half-cycle resolution. A synchronous enable freezes the dividers and silences the pulses. A synchronous clear returns every output to low and takes priority over the enable.

Top module: `pulseClockGen`

## Requirements
- R1: At every rising edge of `clkIn` where `enable` is 1 and `clear` is 0, `clk2` inverts, so that continuous enable gives a period of two input cycles.
- R2: `clk4` inverts at exactly those enabled rising edges at which `clk2` goes from 0 to 1, and holds at every other edge, so that continuous enable gives a period of four input cycles.
- R3: While the pulses are active, the slots decode as follows: `p1` is high for `clk2`=1 with `clkIn`=1, `p2` for `clk2`=1 with `clkIn`=0, `p3` for `clk2`=0 with `clkIn`=1, and `p4` for `clk2`=0 with `clkIn`=0. Each pulse is therefore high for half an input cycle once per two input cycles, in the order p1, p2, p3, p4.
- R4: At most one of `p1` to `p4` is high at any time.
- R5: `p23` is high exactly when `p2` or `p3` is high, so it forms one unbroken pulse spanning slots two and three.
- R6: `enable` is sampled only at rising edges of `clkIn`. A change between edges has no effect on any output until the next rising edge.
- R7: After a rising edge at which `enable` is 0, `clk2` and `clk4` keep their levels and all five pulse outputs are 0 until the next rising edge.
- R8: `clear` is synchronous and active high, and it overrides `enable`. After a rising edge with `clear`=1, `clk2`, `clk4` and all pulse outputs are 0 for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkIn | input | 1 | Input clock; also the fine timing reference for the pulses |
| clear | input | 1 | Synchronous clear, active high |
| enable | input | 1 | Synchronous run enable, active high |
| clk2 | output | 1 | Input clock divided by two |
| clk4 | output | 1 | Input clock divided by four |
| p1 | output | 1 | Slot-one pulse |
| p2 | output | 1 | Slot-two pulse |
| p3 | output | 1 | Slot-three pulse |
| p4 | output | 1 | Slot-four pulse |
| p23 | output | 1 | Merged pulse over slots two and three |

## Verification
Clear and enable can both be high at the same rising edge. The stimulus table provokes this once while the dividers are running, and once more on the edge where clear drops while enable is still high. The first case is judged by all outputs reading low in both halves of the following cycle. The second is judged by the frame restarting at slot one with `clk2` and `clk4` both rising. A directed case also raises enable in the low half of a disabled cycle and checks that the pulses stay silent and that the first slot appears only after the next rising edge.

// File: rtl/pcgPkg.sv
`timescale 1ns/1ps
package pcgPkg;

  // Strobes sent from the control to the divider datapath each cycle.
  typedef struct packed {
    logic clr;   // force dividers low
    logic adv;   // advance dividers by one input cycle
  } pcgStrobeT;

endpackage

// File: rtl/pcgCtrl.sv
`timescale 1ns/1ps
module pcgCtrl
  import pcgPkg::*;
(
  input  logic      clkIn,
  input  logic      clear,
  input  logic      enable,
  output pcgStrobeT strobe,
  output logic      phaseEn
);

  // The run flag is captured at the edge, so a mid-cycle change waits a cycle.
  always_ff @(posedge clkIn) begin
    if (clear) phaseEn <= 1'b0;
    else       phaseEn <= enable;
  end

  // Clear has priority: no advance on a clearing edge.
  always_comb begin
    strobe.clr = clear;
    strobe.adv = enable & ~clear;
  end

endmodule

// File: rtl/pcgDivider.sv
`timescale 1ns/1ps
module pcgDivider
  import pcgPkg::*;
(
  input  logic      clkIn,
  input  pcgStrobeT strobe,
  output logic      clk2,
  output logic      clk4
);

  // Both dividers sit in the input clock domain; clk4 steps on the edge
  // where clk2 is about to rise, which matches a rising-edge toggle of clk2.
  always_ff @(posedge clkIn) begin
    if (strobe.clr) begin
      clk2 <= 1'b0;
      clk4 <= 1'b0;
    end else if (strobe.adv) begin
      clk2 <= ~clk2;
      if (!clk2) clk4 <= ~clk4;
    end
  end

endmodule

// File: rtl/pcgPhaseDecode.sv
`timescale 1ns/1ps
module pcgPhaseDecode (
  input  logic clkIn,
  input  logic clk2,
  input  logic phaseEn,
  output logic p1,
  output logic p2,
  output logic p3,
  output logic p4,
  output logic p23
);

  logic [3:0] slotHot;

  // Slot selection from the two clock levels.
  always_comb begin
    case ({clk2, clkIn})
      2'b11:   slotHot = 4'b0001;
      2'b10:   slotHot = 4'b0010;
      2'b01:   slotHot = 4'b0100;
      default: slotHot = 4'b1000;
    endcase
    if (!phaseEn) slotHot = 4'b0000;
  end

  always_comb begin
    p1  = slotHot[0];
    p2  = slotHot[1];
    p3  = slotHot[2];
    p4  = slotHot[3];
    p23 = slotHot[1] | slotHot[2];
  end

endmodule

// File: rtl/pulseClockGen.sv
`timescale 1ns/1ps
module pulseClockGen
  import pcgPkg::*;
(
  input  logic clkIn,
  input  logic clear,
  input  logic enable,
  output logic clk2,
  output logic clk4,
  output logic p1,
  output logic p2,
  output logic p3,
  output logic p4,
  output logic p23
);

  pcgStrobeT strobe;
  logic      phaseEn;

  pcgCtrl u_ctrl (
    .clkIn   (clkIn),
    .clear   (clear),
    .enable  (enable),
    .strobe  (strobe),
    .phaseEn (phaseEn)
  );

  pcgDivider u_div (
    .clkIn  (clkIn),
    .strobe (strobe),
    .clk2   (clk2),
    .clk4   (clk4)
  );

  pcgPhaseDecode u_dec (
    .clkIn   (clkIn),
    .clk2    (clk2),
    .phaseEn (phaseEn),
    .p1      (p1),
    .p2      (p2),
    .p3      (p3),
    .p4      (p4),
    .p23     (p23)
  );

endmodule

// File: rtl/pulseClockGenChecker.sv
`timescale 1ns/1ps
module pulseClockGenChecker (
  input logic clkIn,
  input logic clear,
  input logic enable,
  input logic clk2,
  input logic clk4,
  input logic p1,
  input logic p2,
  input logic p3,
  input logic p4,
  input logic p23
);

  AST_CLK2_TOGGLE: assert property (@(posedge clkIn) disable iff (clear)
    enable |=> (clk2 != $past(clk2)));  // R1

  AST_CLK4_STEP: assert property (@(posedge clkIn) disable iff (clear)
    (enable && !clk2) |=> (clk4 != $past(clk4)));  // R2

  AST_CLK4_HOLD: assert property (@(posedge clkIn) disable iff (clear)
    (enable && clk2) |=> $stable(clk4));  // R2

  AST_HOLD_DISABLED: assert property (@(posedge clkIn) disable iff (clear)
    !enable |=> ($stable(clk2) && $stable(clk4)));  // R7

  AST_CLEAR_LOW: assert property (@(posedge clkIn)
    clear |=> (!clk2 && !clk4));  // R8

  AST_LOW_HALF_SLOTS: assert property (@(posedge clkIn) disable iff (clear)
    (!p1 && !p3 && (p23 == p2)));  // R3

  AST_HIGH_HALF_SLOTS: assert property (@(negedge clkIn) disable iff (clear)
    (!p2 && !p4 && (p23 == p3)));  // R5

  always_comb begin
    if (!$isunknown({p1, p2, p3, p4})) begin
      AST_ONE_SLOT: assert ($onehot0({p1, p2, p3, p4}));  // R4
    end
  end

endmodule

bind pulseClockGen pulseClockGenChecker u_chk (.*);

// File: tb/pulseClockGen_bench.sv
`timescale 1ns/1ps
module pulseClockGen_bench;

  logic clkIn  = 1'b0;
  logic clear  = 1'b1;
  logic enable = 1'b0;
  logic clk2, clk4, p1, p2, p3, p4, p23;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clkIn = ~clkIn;  // 50 MHz

  pulseClockGen u_pulseClockGen (
    .clkIn  (clkIn),
    .clear  (clear),
    .enable (enable),
    .clk2   (clk2),
    .clk4   (clk4),
    .p1     (p1),
    .p2     (p2),
    .p3     (p3),
    .p4     (p4),
    .p23    (p23)
  );

  // {clear, enable, expected clk2, expected clk4, pulses active} after the edge
  localparam logic [4:0] VEC [0:15] = '{
    5'b10000, 5'b01111, 5'b01011, 5'b01101,
    5'b01001, 5'b00000, 5'b00000, 5'b01111,
    5'b00110, 5'b01011, 5'b11000, 5'b01111,
    5'b01011, 5'b01101, 5'b10000, 5'b01111
  };

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s at %0t: got %b expected %b", req, what, $time, got, exp);
    end
  endtask

  // High half of the input cycle: slot one (clk2=1) or slot three (clk2=0).
  task automatic chkHigh(input string req, input logic c2, input logic c4, input logic act);
    chk("R1", "clk2 high half", clk2, c2);
    chk("R2", "clk4 high half", clk4, c4);
    chk(req,  "p1 high half",   p1,   act & c2);
    chk(req,  "p2 high half",   p2,   1'b0);
    chk(req,  "p3 high half",   p3,   act & ~c2);
    chk(req,  "p4 high half",   p4,   1'b0);
    chk("R5", "p23 high half",  p23,  act & ~c2);
  endtask

  // Low half: slot two (clk2=1) or slot four (clk2=0).
  task automatic chkLow(input string req, input logic c2, input logic c4, input logic act);
    chk("R1", "clk2 low half", clk2, c2);
    chk("R2", "clk4 low half", clk4, c4);
    chk(req,  "p1 low half",   p1,   1'b0);
    chk(req,  "p2 low half",   p2,   act & c2);
    chk(req,  "p3 low half",   p3,   1'b0);
    chk(req,  "p4 low half",   p4,   act & ~c2);
    chk("R5", "p23 low half",  p23,  act & c2);
  endtask

  // Called 3 ns before a rising edge; returns 3 ns before the next one.
  task automatic runCycle(input logic clr, input logic en, input logic c2,
                          input logic c4, input logic act, input string req);
    clear  = clr;
    enable = en;
    @(posedge clkIn);
    #4;  chkHigh(req, c2, c4, act);
    #10; chkLow(req, c2, c4, act);
    #3;
  endtask

  initial begin
    #7;
    // Reset state under clear (R8)
    runCycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
    runCycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R8");

    // Table walk: running, holding, clear with enable (R3, R7, R8)
    for (int i = 0; i < 16; i++) begin
      string req;
      if (VEC[i][4])      req = "R8";
      else if (!VEC[i][3]) req = "R7";
      else                 req = "R3";
      runCycle(VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0], req);
    end

    // Disabled cycle with clk2 and clk4 both high (R7)
    runCycle(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R7");

    // Enable raised in the low half of a disabled cycle (R6)
    clear  = 1'b0;
    enable = 1'b0;
    @(posedge clkIn);
    #4;  chkHigh("R6", 1'b1, 1'b1, 1'b0);
    #8;  enable = 1'b1;               // low half, between edges
    #2;  chkLow("R6", 1'b1, 1'b1, 1'b0);
    #3;
    // The next edge acts on it: clk2 falls, clk4 holds, slot three is live
    runCycle(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R6");
    runCycle(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R3");

    // Clear with enable high at the same edge, then release (R8)
    runCycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R8");
    runCycle(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R2");

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #4000000;
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule